// File: doc/BRIEF.md
# Received Signal Strength Capture Register

This block turns a stream of linear received-power estimates into an 8-bit signal-strength code and holds one such code per receive slot for the host. Each power sample, qualified by a valid strobe, is smoothed by a first-order running average. The average is converted to the log domain with a leading-one detector and a small interpolated fraction table. The result is then scaled so that one code step equals 0.37 dB, and it is clamped to the usable window.

The baseband raises a packet-control strobe once it has recognised the access code of an incoming packet. The first such strobe inside an active receive slot copies the current code into the hold register and raises the valid flag. From then on the held code does not change until a new receive slot starts. The start of a slot re-arms the capture and drops the valid flag, but it leaves the old code in place. The host reads the held value through a simple read port at any time, and reads have no side effects.

Top module: `rssi_hold`

## Requirements
- R1: While reset is asserted and right after it, the held code reads 0, the valid flag is low and the read data is 0. The running average also starts at 0.
- R2: On every cycle with the sample strobe high, the average A becomes A + floor((P - A) / 2^SHIFT), where P is the sample value. The default SHIFT is 3.
- R3: The code for an average A is round(107 + 10*log10(A / 2^REF_EXP) / 0.37), accurate to within one code step. The default REF_EXP is 16.
- R4: An average of 2^REF_EXP is the reference level of -64 dBm, and it yields exactly code 107.
- R5: Codes saturate at 91 (-70 dBm) at the bottom and at 199 (-30 dBm) at the top. An average of 0 yields 91.
- R6: The first packet-control assertion seen while the slot-active level is high loads the code into the hold register and sets the valid flag. Both are visible one clock later.
- R7: A packet-control assertion is ignored if it comes while the slot-active level is low, or if it comes after the capture already made in the current slot. The held code stays the same.
- R8: A rising edge of the slot-active level clears the valid flag on the next clock, keeps the held code, and re-arms capture. A capture in the same cycle as the edge takes precedence.
- R9: When a power sample and the packet-control strobe arrive in the same cycle, the captured code comes from the average as it stood before that sample.
- R10: When the read strobe is high, the read data presents the held code one clock later. Reads never change the held code or the valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_in | input | PW | Linear received-power sample |
| pwr_vld | input | 1 | Sample strobe for pwr_in |
| slot_act | input | 1 | High while a receive slot is active |
| pkt_ctl | input | 1 | Access-code-recognised strobe from the baseband |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 8 | Read data, the held code one clock after rd_en |
| rssi_code | output | 8 | Held signal-strength code |
| rssi_vld | output | 1 | Held code is valid for the current slot |

## Verification
On every cycle, the assertions check the capture and hold sequencing. A valid code always lies within the clamp window. The held code stays put when no packet-control strobe arrives. A slot edge without a strobe drops the valid flag. An armed capture loads the code that was being computed. Read data follows the held code. Only the bench scenarios can show whether the numbers are right. These cover the average update rule, the dB mapping across many power levels, the exact reference and clamp codes, and the choice of the pre-sample average when a sample and a capture coincide.

// File: rtl/rssi_hold.sv
module rssi_hold #(
  parameter int PW      = 32,
  parameter int SHIFT   = 3,
  parameter int REF_EXP = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] pwr_in,
  input  logic          pwr_vld,
  input  logic          slot_act,
  input  logic          pkt_ctl,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  output logic [7:0]    rssi_code,
  output logic          rssi_vld
);
  localparam int EW       = $clog2(PW);
  localparam int CODE_REF = 107;
  localparam int CODE_LO  = CODE_REF - 16;  // 6 dB below reference / 0.37
  localparam int CODE_HI  = CODE_REF + 92;  // 34 dB above reference / 0.37
  localparam int SCALE    = 2083;           // 65536 * 10*log10(2) / (256 * 0.37)

  logic [PW-1:0] avg;
  logic [PW:0]   diff;
  logic [EW-1:0] msb;
  logic [7:0]    mant;
  logic [7:0]    code_now;
  logic          slot_q, armed;

  assign diff = {1'b0, pwr_in} - {1'b0, avg};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) avg <= '0;
    else if (pwr_vld) avg <= avg + PW'($signed(diff) >>> SHIFT);

  always_comb begin
    msb = '0;
    for (int i = 0; i < PW; i++)
      if (avg[i]) msb = EW'(i);
  end

  assign mant = 8'((avg << (EW'(PW-1) - msb)) >> (PW-9));

  function automatic int frac_lut(input int i);
    case (i)
      0: return 0;    1: return 22;   2: return 44;   3: return 63;
      4: return 82;   5: return 100;  6: return 118;  7: return 134;
      8: return 150;  9: return 165;  10: return 179; 11: return 193;
      12: return 207; 13: return 220; 14: return 232; 15: return 244;
      default: return 256;
    endcase
  endfunction

  always_comb begin
    int hi, lo, lg, off, c;
    lo  = frac_lut(int'(mant[7:4]));
    hi  = frac_lut(int'(mant[7:4]) + 1);
    lg  = int'(msb) * 256 + lo + (((hi - lo) * int'(mant[3:0])) >>> 4);
    off = ((lg - REF_EXP * 256) * SCALE + 32768) >>> 16;
    c   = CODE_REF + off;
    if (avg == '0 || c < CODE_LO) c = CODE_LO;
    if (c > CODE_HI) c = CODE_HI;
    code_now = 8'(c);
  end

  wire slot_rise = slot_act & ~slot_q;
  wire capture   = pkt_ctl & slot_act & (armed | slot_rise);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      slot_q    <= 1'b0;
      armed     <= 1'b0;
      rssi_code <= '0;
      rssi_vld  <= 1'b0;
      rd_data   <= '0;
    end else begin
      slot_q <= slot_act;
      if (capture) begin
        rssi_code <= code_now;
        rssi_vld  <= 1'b1;
        armed     <= 1'b0;
      end else if (slot_rise) begin
        rssi_vld <= 1'b0;
        armed    <= 1'b1;
      end
      if (rd_en) rd_data <= rssi_code;
    end
endmodule

// File: rtl/rssi_hold_chk.sv
module rssi_hold_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       slot_act,
  input logic       pkt_ctl,
  input logic       rd_en,
  input logic [7:0] rd_data,
  input logic [7:0] rssi_code,
  input logic       rssi_vld,
  input logic       armed,
  input logic [7:0] code_now
);
  AST_CODE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    rssi_vld |-> (rssi_code >= 8'd91 && rssi_code <= 8'd199)); // R5
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_ctl |=> $stable(rssi_code)); // R7
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_act && !rssi_vld) |=> !rssi_vld); // R7
  AST_SLOT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(slot_act) && !pkt_ctl) |=> !rssi_vld); // R8
  AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && slot_act && pkt_ctl) |=> (rssi_vld && rssi_code == $past(code_now))); // R6
  AST_READ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_data == $past(rssi_code)); // R10
endmodule

bind rssi_hold rssi_hold_chk chk (
  .clk, .rst_n, .slot_act, .pkt_ctl, .rd_en, .rd_data,
  .rssi_code, .rssi_vld, .armed, .code_now
);

// File: tb/rssi_hold_test.sv
module rssi_hold_test;
  localparam int SHIFT = 3;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] pwr_in = '0;
  logic        pwr_vld = 1'b0, slot_act = 1'b0, pkt_ctl = 1'b0, rd_en = 1'b0;
  logic [7:0]  rd_data, rssi_code;
  logic        rssi_vld;

  int nchk = 0, nerr = 0;
  longint avg_m = 0;
  bit sa_m = 0, armed_m = 0, vld_m = 0;
  int held_m = 0;

  always #4 clk = ~clk;

  rssi_hold uut (.clk, .rst_n, .pwr_in, .pwr_vld, .slot_act, .pkt_ctl,
                 .rd_en, .rd_data, .rssi_code, .rssi_vld);

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_code(input longint a);
    real r;
    if (a <= 0) return 91;
    r = 107.0 + 10.0 * $log10(real'(a) / 65536.0) / 0.37;
    if (r < 91.0) r = 91.0;
    if (r > 199.0) r = 199.0;
    return $rtoi(r + 0.5);
  endfunction

  task automatic step(input bit pv, input longint p, input bit sa, input bit pc,
                      input bit re, input string tag = "R3", input bit exact = 0);
    bit rise, cap;
    int e, old;
    pwr_in = p[31:0]; pwr_vld = pv; slot_act = sa; pkt_ctl = pc; rd_en = re;
    rise = sa && !sa_m;
    cap  = pc && sa && (armed_m || rise);
    e    = exp_code(avg_m);
    old  = int'(rssi_code);
    @(posedge clk); #2;
    if (pv) avg_m = avg_m + ((p - avg_m) >>> SHIFT);
    sa_m = sa;
    if (cap) begin
      armed_m = 0; vld_m = 1;
      if (exact) check(int'(rssi_code) == e, tag, rssi_code, e);
      else check(int'(rssi_code) - e <= 1 && e - int'(rssi_code) <= 1, tag, rssi_code, e);
      held_m = int'(rssi_code);
    end else begin
      if (rise) begin armed_m = 1; vld_m = 0; end
      check(int'(rssi_code) == held_m, "R7 held code unchanged", rssi_code, held_m);
    end
    check(rssi_vld == vld_m, "R8 valid flag", rssi_vld, vld_m);
    if (re) check(int'(rd_data) == old, "R10 read data", rd_data, old);
  endtask

  task automatic grab(input string tag, input bit exact);
    step(0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 1, 0, tag, exact);
    step(0, 0, 1, 0, 1);
  endtask

  task automatic feed(input longint p, input int n);
    for (int i = 0; i < n; i++) step(1, p, sa_m, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    check(rssi_code == 8'd0, "R1 reset code", rssi_code, 0);
    check(rssi_vld == 1'b0, "R1 reset valid", rssi_vld, 0);
    check(rd_data == 8'd0, "R1 reset read data", rd_data, 0);
    // R7: strobe outside a slot
    step(0, 0, 0, 1, 0);
    check(rssi_vld == 1'b0, "R7 idle strobe ignored", rssi_vld, 0);
    // R5: empty average gives the floor
    grab("R5 zero average", 1);
    // R2: a single sample from zero moves the average by 1/8 of the step
    step(0, 0, 0, 0, 0);
    step(1, 64'd16777216, 0, 0, 0);
    grab("R2 single sample update", 0);
    // R4: reference level
    feed(65536, 160);
    grab("R4 reference code", 1);
    // R7: a second strobe in the same slot, with new power, is ignored
    feed(64'd4000000000, 30);
    step(0, 0, 1, 1, 1);
    check(int'(rssi_code) == 107, "R7 second strobe", rssi_code, 107);
    // R8: slot edge alone drops valid, keeps code
    step(0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    check(rssi_vld == 1'b0 && rssi_code == 8'd107, "R8 slot edge", rssi_code, 107);
    feed(65536, 200);
    // R9: sample and strobe in the same cycle use the older average
    step(0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    step(1, 64'd2147483648, 1, 1, 0, "R9 pre-sample average", 1);
    // R5: saturation at both ends
    feed(64'd4294967295, 220);
    grab("R5 upper clamp", 1);
    feed(1, 320);
    grab("R5 lower clamp", 1);
    // R3: sweep of power levels over mantissas and octaves
    for (int s = 0; s < 28; s++)
      for (int m = 8; m < 16; m++) begin
        feed(longint'(m) << s, 40);
        grab("R3 mapping sweep", 0);
      end
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule